// File: doc/BRIEF.md
# Inertial Sensor Burst Reader

This block is the host side of a streaming SPI read from a six-axis inertial sensor. A single trigger makes the engine pull chip select low and send one 16-bit command frame carrying the burst opcode. Chip select then stays low while ten more 16-bit frames are clocked in back to back, with no pause between frames. In arrival order these are a status word, three angular-rate words (X, Y, Z), three acceleration words (X, Y, Z), a temperature word, a sample counter and a checksum word.

While the words arrive, the engine adds up the two bytes of each of the first nine words as unsigned 8-bit values. It compares that sum with the tenth word. Once chip select is released, the whole record and the mismatch flag are published together, marked by a single-cycle valid strobe. A burst starts either on a host pulse or on a rising edge of the sensor's data-ready line, when that source is enabled.

Top module: `burst_reader`

## Requirements
- R1: After chip select falls, the first 16 bits sent on `mosi_o`, MSB first, are 0x3E00. Every later bit of the burst is 0.
- R2: Chip select stays low for exactly 11 × 16 = 176 SCLK periods without gaps. SCLK idles high and is high whenever chip select is high. `mosi_o` changes after falling edges of SCLK and `miso_i` is sampled on its rising edges.
- R3: Each SCLK half period lasts HALF_DIV system clock cycles, so rising edges are 2·HALF_DIV cycles apart.
- R4: Frame k+1 of the burst (k = 0..9) is placed in `data_o[16k+15:16k]`. The bits received during the command frame are discarded.
- R5: `csum_err_o` is 1 exactly when the 16-bit sum of the high and low bytes of words 0..8 differs from word 9. An all-0xFFFF record sums to 0x11EE.
- R6: `valid_o` is high for one cycle, in the same cycle chip select returns high. `data_o` and `csum_err_o` change only in that cycle and hold their values in between.
- R7: `busy_o` is high from the cycle chip select falls until it rises. A trigger that arrives while busy starts no further burst.
- R8: With `drdy_en_i` = 1, a rising edge of `drdy_i` starts one burst. A level held high starts no more. With `drdy_en_i` = 0 the line has no effect.
- R9: In reset, `cs_no` and `sclk_o` are 1, and `busy_o`, `valid_o`, `csum_err_o`, `mosi_o` and `data_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Host burst request pulse |
| drdy_i | input | 1 | Sensor data-ready line (asynchronous) |
| drdy_en_i | input | 1 | Enables data-ready triggering |
| miso_i | input | 1 | Serial data from sensor |
| sclk_o | output | 1 | Serial clock, idle high |
| cs_no | output | 1 | Chip select, active low |
| mosi_o | output | 1 | Serial data to sensor |
| busy_o | output | 1 | Burst in progress |
| valid_o | output | 1 | One-cycle strobe for a new record |
| csum_err_o | output | 1 | Checksum mismatch for the published record |
| data_o | output | 160 | Ten received words, word 0 in the low bits |

## Verification
The bench goes after off-by-one framing. A reader that kept the command-frame bits, or dropped one SCLK period, would shift every word and fail the per-slot comparison. All-ones payloads drive the byte sum to its largest value, 0x11EE; an 8-bit accumulator, or a sum taken over whole words instead of bytes, would raise a false mismatch there. A burst with a single corrupted checksum bit must raise the flag. A second trigger during a burst, and a data-ready line held high, would both show up as an extra chip-select fall if the engine re-armed on a level or while busy.

// File: rtl/burst_pkg.sv
package burst_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_XFER, ST_TAIL} burst_st_e;
endpackage

// File: rtl/burst_trig.sv
module burst_trig (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic rise_o
);
  logic [2:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[1:0], line_i};
  end

  assign rise_o = sync_q[1] & ~sync_q[2];

  AST_RISE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o); // R8
endmodule

// File: rtl/burst_sclk.sv
module burst_sclk #(
  parameter int HALF_DIV = 125
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic sclk_o,
  output logic fall_o,
  output logic rise_o
);
  localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [DIV_W-1:0] cnt_q;
  logic             sclk_q;
  logic             tick;

  assign tick = run_i && (cnt_q == DIV_W'(HALF_DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sclk_q <= 1'b1;
    end else if (!run_i) begin
      cnt_q  <= '0;
      sclk_q <= 1'b1;
    end else if (tick) begin
      cnt_q  <= '0;
      sclk_q <= ~sclk_q;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign sclk_o = sclk_q;
  assign fall_o = tick & sclk_q;
  assign rise_o = tick & ~sclk_q;

  AST_SCLK_PARKS_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> sclk_o); // R2
endmodule

// File: rtl/burst_csum.sv
module burst_csum #(
  parameter int WORD_W  = 16,
  parameter int N_TERMS = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              add_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              match_o
);
  localparam int HALF_W  = WORD_W / 2;
  localparam int MAX_SUM = N_TERMS * 2 * ((1 << HALF_W) - 1);

  logic [WORD_W-1:0] sum_q;
  logic [WORD_W-1:0] byte_sum;

  assign byte_sum = WORD_W'(word_i[WORD_W-1:HALF_W]) + WORD_W'(word_i[HALF_W-1:0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sum_q <= '0;
    else if (clr_i)  sum_q <= '0;
    else if (add_i)  sum_q <= sum_q + byte_sum;
  end

  assign match_o = (sum_q == word_i);

  AST_SUM_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(sum_q) <= MAX_SUM); // R5
endmodule

// File: rtl/burst_reader.sv
module burst_reader
  import burst_pkg::*;
#(
  parameter int              HALF_DIV = 125,
  parameter int              N_WORDS  = 10,
  parameter int              WORD_W   = 16,
  parameter logic [15:0]     CMD_WORD = 16'h3E00
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        start_i,
  input  logic                        drdy_i,
  input  logic                        drdy_en_i,
  input  logic                        miso_i,
  output logic                        sclk_o,
  output logic                        cs_no,
  output logic                        mosi_o,
  output logic                        busy_o,
  output logic                        valid_o,
  output logic                        csum_err_o,
  output logic [N_WORDS*WORD_W-1:0]   data_o
);
  localparam int BIT_W = $clog2(WORD_W);
  localparam int IDX_W = $clog2(N_WORDS + 1);
  localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  burst_st_e         state_q;
  logic              cs_q, mosi_q, valid_q, err_q, err_pend_q;
  logic [WORD_W-1:0] tx_q, rx_q, rx_next;
  logic [BIT_W-1:0]  bit_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DIV_W-1:0]  tail_q;
  logic [WORD_W-1:0] shadow_q [N_WORDS];
  logic [N_WORDS*WORD_W-1:0] data_q;

  logic drdy_rise, trigger, launch;
  logic sclk_fall, sclk_rise;
  logic word_done, data_word, last_word, csum_match;

  burst_trig i_trig (
    .clk_i (clk_i), .rst_ni (rst_ni), .line_i (drdy_i), .rise_o (drdy_rise)
  );

  burst_sclk #(.HALF_DIV (HALF_DIV)) i_sclk (
    .clk_i (clk_i), .rst_ni (rst_ni), .run_i (state_q == ST_XFER),
    .sclk_o (sclk_o), .fall_o (sclk_fall), .rise_o (sclk_rise)
  );

  assign rx_next   = {rx_q[WORD_W-2:0], miso_i};
  assign word_done = sclk_rise && (bit_q == BIT_W'(WORD_W - 1));
  assign data_word = word_done && (idx_q != '0);
  assign last_word = (idx_q == IDX_W'(N_WORDS));
  assign trigger   = start_i | (drdy_en_i & drdy_rise);
  assign launch    = trigger && (state_q == ST_IDLE);

  burst_csum #(.WORD_W (WORD_W), .N_TERMS (N_WORDS - 1)) i_csum (
    .clk_i (clk_i), .rst_ni (rst_ni), .clr_i (launch),
    .add_i (data_word && !last_word), .word_i (rx_next), .match_o (csum_match)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cs_q       <= 1'b1;
      mosi_q     <= 1'b0;
      tx_q       <= '0;
      rx_q       <= '0;
      bit_q      <= '0;
      idx_q      <= '0;
      tail_q     <= '0;
      valid_q    <= 1'b0;
      err_q      <= 1'b0;
      err_pend_q <= 1'b0;
      data_q     <= '0;
      for (int k = 0; k < N_WORDS; k++) shadow_q[k] <= '0;
    end else begin
      valid_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (launch) begin
          state_q <= ST_XFER;
          cs_q    <= 1'b0;
          tx_q    <= WORD_W'(CMD_WORD);
          bit_q   <= '0;
          idx_q   <= '0;
        end
        ST_XFER: begin
          if (sclk_fall) begin
            mosi_q <= tx_q[WORD_W-1];
            tx_q   <= tx_q << 1;
          end
          if (sclk_rise) begin
            rx_q  <= rx_next;
            bit_q <= word_done ? '0 : bit_q + 1'b1;
          end
          if (word_done) begin
            idx_q <= idx_q + 1'b1;
            // frame 0 is the command slot: nothing stored
            if (data_word) shadow_q[IDX_W'(idx_q - 1'b1)] <= rx_next;
            if (last_word) begin
              err_pend_q <= ~csum_match;
              state_q    <= ST_TAIL;
              tail_q     <= '0;
            end
          end
        end
        ST_TAIL: begin
          mosi_q <= 1'b0;
          tail_q <= tail_q + 1'b1;
          if (tail_q == DIV_W'(HALF_DIV - 1)) begin
            state_q <= ST_IDLE;
            cs_q    <= 1'b1;
            valid_q <= 1'b1;
            err_q   <= err_pend_q;
            for (int k = 0; k < N_WORDS; k++) data_q[k*WORD_W +: WORD_W] <= shadow_q[k];
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cs_no      = cs_q;
  assign mosi_o     = mosi_q;
  assign busy_o     = (state_q != ST_IDLE);
  assign valid_o    = valid_q;
  assign csum_err_o = err_q;
  assign data_o     = data_q;

  AST_CS_LOW_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_no |-> busy_o); // R7
  AST_SCLK_HIGH_DESELECTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> sclk_o); // R2
  AST_VALID_AT_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (valid_o && cs_no)); // R6
  AST_VALID_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o); // R6
  AST_RECORD_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> ($stable(data_o) && $stable(csum_err_o))); // R6
endmodule

// File: tb/test_burst_reader.sv
module test_burst_reader;
  localparam int HALF = 3;
  localparam int NW   = 10;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic start_i = 1'b0, drdy_i = 1'b0, drdy_en_i = 1'b0, miso_i = 1'b0;
  logic sclk_o, cs_no, mosi_o, busy_o, valid_o, csum_err_o;
  logic [NW*16-1:0] data_o;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  burst_reader #(.HALF_DIV (HALF)) i_burst_reader (
    .clk_i (clk), .rst_ni (rst_ni), .start_i (start_i), .drdy_i (drdy_i),
    .drdy_en_i (drdy_en_i), .miso_i (miso_i), .sclk_o (sclk_o), .cs_no (cs_no),
    .mosi_o (mosi_o), .busy_o (busy_o), .valid_o (valid_o),
    .csum_err_o (csum_err_o), .data_o (data_o)
  );

  // sensor model, SPI mode 3
  logic [175:0] frame;
  logic [15:0]  mosi_cap;
  int bit_idx = 0, rise_cnt = 0, cs_falls = 0, late_ones = 0, gap_bad = 0;
  time last_rise = 0;

  always @(negedge cs_no) begin
    bit_idx = 0; rise_cnt = 0; late_ones = 0; gap_bad = 0; cs_falls++;
  end
  always @(negedge sclk_o) if (!cs_no) begin
    miso_i = frame[175 - bit_idx];
    bit_idx++;
  end
  always @(posedge sclk_o) if (!cs_no) begin
    if (rise_cnt < 16) mosi_cap = {mosi_cap[14:0], mosi_o};
    else if (mosi_o) late_ones++;
    if (rise_cnt > 0 && ($time - last_rise) != 2 * HALF * 4) gap_bad++;
    last_rise = $time;
    rise_cnt++;
  end

  task automatic chk(input bit ok, input string req, input logic [159:0] act, input logic [159:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] byte_sum(input logic [15:0] w [9]);
    logic [15:0] s = '0;
    for (int k = 0; k < 9; k++) s += 16'(w[k][15:8]) + 16'(w[k][7:0]);
    return s;
  endfunction

  logic [15:0] pl [NW];
  logic [159:0] exp_rec;

  task automatic prepare(input int mode, input bit corrupt);
    logic [15:0] d [9];
    for (int k = 0; k < 9; k++) begin
      d[k] = (mode == 1) ? 16'hFFFF : (mode == 2) ? 16'h0000 : 16'($urandom);
      pl[k] = d[k];
    end
    pl[9] = byte_sum(d) ^ (corrupt ? 16'h0100 : 16'h0000);
    frame = {16'($urandom), pl[0], pl[1], pl[2], pl[3], pl[4], pl[5], pl[6], pl[7], pl[8], pl[9]};
    for (int k = 0; k < NW; k++) exp_rec[k*16 +: 16] = pl[k];
  endtask

  task automatic wait_valid(output bit seen);
    int n = 0;
    seen = 1'b0;
    while (n < 4000) begin
      @(negedge clk);
      if (valid_o) begin seen = 1'b1; break; end
      n++;
    end
  endtask

  task automatic check_record(input bit corrupt, input string tag);
    bit seen;
    wait_valid(seen);
    chk(seen, {"R6 valid seen ", tag}, 160'(seen), 160'd1);
    chk(cs_no && !busy_o, {"R6 R7 valid at release ", tag}, 160'({cs_no, busy_o}), 160'b10);
    chk(data_o == exp_rec, {"R4 record ", tag}, data_o, exp_rec);
    chk(csum_err_o == corrupt, {"R5 csum flag ", tag}, 160'(csum_err_o), 160'(corrupt));
    chk(mosi_cap == 16'h3E00 && late_ones == 0, {"R1 command ", tag}, 160'({mosi_cap, 16'(late_ones)}), 160'({16'h3E00, 16'd0}));
    chk(rise_cnt == 176, {"R2 sclk count ", tag}, 160'(rise_cnt), 160'd176);
    chk(gap_bad == 0, {"R3 sclk period ", tag}, 160'(gap_bad), 160'd0);
    @(negedge clk);
    chk(!valid_o, {"R6 single pulse ", tag}, 160'(valid_o), 160'd0);
    repeat (20) @(negedge clk);
    chk(data_o == exp_rec && csum_err_o == corrupt, {"R6 hold ", tag}, data_o, exp_rec);
  endtask

  task automatic pulse_start();
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
  endtask

  initial begin
    int falls0;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk(cs_no && sclk_o && !busy_o && !valid_o && !csum_err_o && !mosi_o && data_o == '0,
        "R9 reset state", 160'({cs_no, sclk_o, busy_o, valid_o, csum_err_o, mosi_o}), 160'b110000);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);

    prepare(1, 1'b0); pulse_start(); check_record(1'b0, "all ones R5");
    prepare(2, 1'b0); pulse_start(); check_record(1'b0, "all zeros");
    prepare(0, 1'b1); pulse_start(); check_record(1'b1, "corrupt R5");
    for (int i = 0; i < 5; i++) begin
      bit c = 1'($urandom);
      prepare(0, c); pulse_start(); check_record(c, "random");
    end

    // R7: retrigger while busy
    prepare(0, 1'b0);
    falls0 = cs_falls;
    pulse_start();
    repeat (200) @(negedge clk);
    chk(busy_o && !cs_no, "R7 busy mid burst", 160'({busy_o, cs_no}), 160'b10);
    pulse_start();
    check_record(1'b0, "retrigger R7");
    repeat (40) @(negedge clk);
    chk(cs_falls == falls0 + 1 && cs_no && !busy_o, "R7 retrigger ignored", 160'(cs_falls - falls0), 160'd1);

    // R8: data-ready disabled
    falls0 = cs_falls;
    drdy_i = 1'b1;
    repeat (30) @(negedge clk);
    chk(cs_falls == falls0 && cs_no, "R8 drdy disabled", 160'(cs_falls - falls0), 160'd0);
    drdy_i = 1'b0;
    repeat (5) @(negedge clk);

    // R8: data-ready enabled, level held
    drdy_en_i = 1'b1;
    prepare(0, 1'b0);
    drdy_i = 1'b1;
    check_record(1'b0, "drdy R8");
    repeat (60) @(negedge clk);
    chk(cs_falls == falls0 + 1 && cs_no, "R8 single burst per edge", 160'(cs_falls - falls0), 160'd1);
    drdy_i = 1'b0;
    repeat (5) @(negedge clk);
    prepare(0, 1'b1);
    drdy_i = 1'b1;
    check_record(1'b1, "drdy second edge R8");
    drdy_i = 1'b0;

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule